// File: doc/BRIEF.md
# Five-Stage Interlocked Integer Pipeline

This block is a small in-order processor core built as five stages: instruction fetch, decode with register-file read, execute (ALU work or address formation), data-memory access and register writeback. It runs four instructions: word load, word store, two-register add and signed set-less-than against an immediate. The instruction and data memories are internal word arrays. The environment fills them through preload ports while the core is held in reset, and reads them back, along with any register, through combinational peek ports.

Data dependencies are never bypassed between stages. When a decoded instruction names a source register that an older instruction in execute or memory still has to write, the decode stage holds it there and sends empty slots into execute until the producer reaches writeback. The register file lets a value being written back in a cycle be seen by decode in that same cycle. Each recognised instruction raises a one-cycle retire pulse as it passes writeback, so the effect of every interlock can be seen at the ports.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc` becomes 0, every pipeline slot becomes empty and every register reads 0. During and right after reset, `retire` is low.
- R2: In each cycle without a stall, fetch reads the instruction word at index `fetch_pc[IA+1:2]` and `fetch_pc` increases by 4 at the next edge. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift [10:6], function [5:0], immediate [15:0].
- R3: Load (opcode 0x23): the address is rs plus the sign-extended immediate, formed in execute. The data word at index address[DA+1:2] is read in the memory stage and written to rt in writeback.
- R4: Store (opcode 0x2B): both rs and rt are read in decode. The rt value is written to the data word at index (rs + sign-extended immediate)[DA+1:2] in the memory stage. No register is written.
- R5: Add (opcode 0, function 0x20, shift field 0): rd receives rs + rt modulo 2^32.
- R6: Set-less-than-immediate (opcode 0x0A): rt receives 1 if rs is less than the sign-extended immediate as signed 32-bit values, and 0 otherwise.
- R7: An instruction whose source register (nonzero) is the destination of an older recognised instruction in execute or memory waits in decode. A dependency on the instruction directly ahead costs two stall cycles, one instruction further back costs one, and three or more back costs none.
- R8: During a stall, `fetch_pc` and the fetch/decode register keep their values, and an empty slot (no register write, no memory write, no retire) enters execute.
- R9: A register being written back in a cycle is read with its new value by the instruction in decode in that same cycle.
- R10: Register 0 always reads as 0. Writes to it are discarded, and it never causes a stall.
- R11: Any other encoding is a no-op. It writes no register or memory, causes no stall, and does not raise `retire`.
- R12: `retire` is high for exactly one cycle for each recognised instruction. That cycle is the one in which the instruction sits in writeback, three cycles after it leaves decode.
- R13: Preload writes place words at the given indices of the instruction and data memories. The peek ports return the addressed register (with R10) and data word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_load_en | input | 1 | Write enable for instruction preload |
| imem_load_idx | input | IA | Instruction word index to write |
| imem_load_word | input | 32 | Instruction word to write |
| dmem_load_en | input | 1 | Write enable for data preload |
| dmem_load_idx | input | DA | Data word index to write |
| dmem_load_word | input | 32 | Data word to write |
| peek_reg_idx | input | 5 | Register to observe |
| peek_reg_val | output | 32 | Value of the observed register |
| peek_mem_idx | input | DA | Data word index to observe |
| peek_mem_val | output | 32 | Value of the observed data word |
| fetch_pc | output | 32 | Byte address being fetched this cycle |
| retire | output | 1 | A recognised instruction is in writeback |

IA is log2(IMEM_WORDS) and DA is log2(DMEM_WORDS).

## Verification
The bench keeps the instruction memory at its default of 64 words and shrinks the data memory to 16 words, so the whole data memory can be compared word by word after the run. Sixty-four instruction words leave room for a 17-instruction program with 11 stall cycles to finish long before the fetch address wraps. Sixteen data words still reach a store that lands on the word a later load reads. With these sizes, distance-one and distance-two dependencies through every source field, an unknown encoding whose source field names a pending register, a write to register 0 and a store-then-load through memory all fall inside one program whose retire and fetch timing is compared every cycle.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef enum logic [2:0] {
    K_NOP   = 3'd0,
    K_LOAD  = 3'd1,
    K_STORE = 3'd2,
    K_ADD   = 3'd3,
    K_SLTI  = 3'd4
  } kind_e;

  // Decoded view of one instruction
  typedef struct packed {
    kind_e             kind;
    logic              use_a;
    logic [RIDX-1:0]   src_a;
    logic              use_b;
    logic [RIDX-1:0]   src_b;
    logic              wr_reg;
    logic [RIDX-1:0]   dst;
    logic [XLEN-1:0]   imm;
  } dec_t;

  typedef struct packed {
    dec_t            dec;
    logic [XLEN-1:0] a_val;
    logic [XLEN-1:0] b_val;
  } idex_t;

  typedef struct packed {
    kind_e           kind;
    logic            wr_reg;
    logic [RIDX-1:0] dst;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] sdata;
  } exmem_t;

  typedef struct packed {
    kind_e           kind;
    logic            wr_reg;
    logic [RIDX-1:0] dst;
    logic [XLEN-1:0] wdata;
  } memwb_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] slt_signed(input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b);
    return ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
  endfunction

  // Execute-stage result: sum, comparison or memory address
  function automatic logic [XLEN-1:0] ex_compute(input kind_e k,
                                                 input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b,
                                                 input logic [XLEN-1:0] imm);
    case (k)
      K_ADD:           return a + b;
      K_SLTI:          return slt_signed(a, imm);
      K_LOAD, K_STORE: return a + imm;
      default:         return '0;
    endcase
  endfunction

endpackage

// File: rtl/pipe5_decoder.sv
module pipe5_decoder
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);

  logic [5:0]      opc;
  logic [5:0]      fn;
  logic [RIDX-1:0] rs;
  logic [RIDX-1:0] rt;
  logic [RIDX-1:0] rd;
  logic [4:0]      sh;

  assign opc = instr[31:26];
  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign rd  = instr[15:11];
  assign sh  = instr[10:6];
  assign fn  = instr[5:0];

  always_comb begin
    dec      = '0;
    dec.kind = K_NOP;
    dec.imm  = sext16(instr[15:0]);
    case (opc)
      OP_LOAD: begin
        dec.kind   = K_LOAD;
        dec.use_a  = 1'b1;
        dec.src_a  = rs;
        dec.dst    = rt;
        dec.wr_reg = (rt != '0);
      end
      OP_STORE: begin
        dec.kind  = K_STORE;
        dec.use_a = 1'b1;
        dec.src_a = rs;
        dec.use_b = 1'b1;
        dec.src_b = rt;
      end
      OP_SLTI: begin
        dec.kind   = K_SLTI;
        dec.use_a  = 1'b1;
        dec.src_a  = rs;
        dec.dst    = rt;
        dec.wr_reg = (rt != '0);
      end
      OP_RTYPE: begin
        if (fn == FN_ADD && sh == '0) begin
          dec.kind   = K_ADD;
          dec.use_a  = 1'b1;
          dec.src_a  = rs;
          dec.use_b  = 1'b1;
          dec.src_b  = rt;
          dec.dst    = rd;
          dec.wr_reg = (rd != '0);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
#(
  parameter int NRD = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [RIDX-1:0]      waddr,
  input  logic [XLEN-1:0]      wdata,
  input  logic [NRD*RIDX-1:0]  raddr,
  output logic [NRD*XLEN-1:0]  rdata
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  // Write-before-read: a value being written this cycle is returned at once
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [RIDX-1:0] ra;
    assign ra = raddr[g*RIDX +: RIDX];
    assign rdata[g*XLEN +: XLEN] =
      (ra == '0)                ? '0    :
      (we && waddr == ra)       ? wdata :
                                  regs[ra];
  end

  // R9
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard
  import pipe5_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0]      use_src,
  input  logic [NSRC*RIDX-1:0] src_idx,
  input  logic                 ex_wr,
  input  logic [RIDX-1:0]      ex_dst,
  input  logic                 mem_wr,
  input  logic [RIDX-1:0]      mem_dst,
  output logic                 stall
);

  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [RIDX-1:0] s;
    assign s = src_idx[g*RIDX +: RIDX];
    assign hit[g] = use_src[g] && (s != '0) &&
                    ((ex_wr && ex_dst == s) || (mem_wr && mem_dst == s));
  end

  assign stall = |hit;

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IA = $clog2(IMEM_WORDS),
  localparam int DA = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_load_en,
  input  logic [IA-1:0]   imem_load_idx,
  input  logic [31:0]     imem_load_word,
  input  logic            dmem_load_en,
  input  logic [DA-1:0]   dmem_load_idx,
  input  logic [31:0]     dmem_load_word,
  input  logic [4:0]      peek_reg_idx,
  output logic [31:0]     peek_reg_val,
  input  logic [DA-1:0]   peek_mem_idx,
  output logic [31:0]     peek_mem_val,
  output logic [31:0]     fetch_pc,
  output logic            retire
);

  // ---------------- storage ----------------
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // ---------------- pipeline registers ----------------
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] ifid_q;
  idex_t           idex_q;
  exmem_t          exmem_q;
  memwb_t          memwb_q;

  // named internal events
  logic            stall;
  dec_t            id_dec;
  logic [XLEN-1:0] id_a;
  logic [XLEN-1:0] id_b;
  logic [XLEN-1:0] ex_res;
  logic            mem_store;
  logic [XLEN-1:0] mem_rdata;
  logic            wb_we;

  // ---------------- fetch ----------------
  always_ff @(posedge clk) begin
    if (imem_load_en) imem[imem_load_idx] <= imem_load_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ifid_q <= '0;
    end else if (!stall) begin
      pc_q   <= pc_q + 32'd4;
      ifid_q <= imem[pc_q[IA+1:2]];
    end
  end

  assign fetch_pc = pc_q;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (pc_q == $past(pc_q) + 32'd4));

  // ---------------- decode ----------------
  pipe5_decoder i_dec (
    .instr (ifid_q),
    .dec   (id_dec)
  );

  logic [3*XLEN-1:0] rf_rdata;

  pipe5_regfile #(.NRD(3)) i_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wb_we),
    .waddr (memwb_q.dst),
    .wdata (memwb_q.wdata),
    .raddr ({peek_reg_idx, id_dec.src_b, id_dec.src_a}),
    .rdata (rf_rdata)
  );

  assign id_a         = rf_rdata[0*XLEN +: XLEN];
  assign id_b         = rf_rdata[1*XLEN +: XLEN];
  assign peek_reg_val = rf_rdata[2*XLEN +: XLEN];

  pipe5_hazard #(.NSRC(2)) i_haz (
    .use_src ({id_dec.use_b, id_dec.use_a}),
    .src_idx ({id_dec.src_b, id_dec.src_a}),
    .ex_wr   (idex_q.dec.wr_reg),
    .ex_dst  (idex_q.dec.dst),
    .mem_wr  (exmem_q.wr_reg),
    .mem_dst (exmem_q.dst),
    .stall   (stall)
  );

  always_ff @(posedge clk) begin
    if (rst || stall) begin
      idex_q <= '0;
    end else begin
      idex_q.dec   <= id_dec;
      idex_q.a_val <= id_a;
      idex_q.b_val <= id_b;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(pc_q) && $stable(ifid_q)));

  // R8
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (idex_q.dec.kind == K_NOP && !idex_q.dec.wr_reg));

  // ---------------- execute ----------------
  assign ex_res = ex_compute(idex_q.dec.kind, idex_q.a_val, idex_q.b_val,
                             idex_q.dec.imm);

  always_ff @(posedge clk) begin
    if (rst) begin
      exmem_q <= '0;
    end else begin
      exmem_q.kind   <= idex_q.dec.kind;
      exmem_q.wr_reg <= idex_q.dec.wr_reg;
      exmem_q.dst    <= idex_q.dec.dst;
      exmem_q.res    <= ex_res;
      exmem_q.sdata  <= idex_q.b_val;
    end
  end

  // R7: no instruction reaches execute while its source is still pending in memory
  // R7
  no_raw_chk: assert property (@(posedge clk) disable iff (rst)
    !(exmem_q.wr_reg &&
      ((idex_q.dec.use_a && idex_q.dec.src_a != '0 && idex_q.dec.src_a == exmem_q.dst) ||
       (idex_q.dec.use_b && idex_q.dec.src_b != '0 && idex_q.dec.src_b == exmem_q.dst))));

  // ---------------- memory ----------------
  assign mem_store = (exmem_q.kind == K_STORE);
  assign mem_rdata = dmem[exmem_q.res[DA+1:2]];

  always_ff @(posedge clk) begin
    if (dmem_load_en)   dmem[dmem_load_idx]       <= dmem_load_word;
    else if (mem_store) dmem[exmem_q.res[DA+1:2]] <= exmem_q.sdata;
  end

  assign peek_mem_val = dmem[peek_mem_idx];

  // R4
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    mem_store |-> !exmem_q.wr_reg);

  always_ff @(posedge clk) begin
    if (rst) begin
      memwb_q <= '0;
    end else begin
      memwb_q.kind   <= exmem_q.kind;
      memwb_q.wr_reg <= exmem_q.wr_reg;
      memwb_q.dst    <= exmem_q.dst;
      memwb_q.wdata  <= (exmem_q.kind == K_LOAD) ? mem_rdata : exmem_q.res;
    end
  end

  // ---------------- writeback ----------------
  assign wb_we  = memwb_q.wr_reg;
  assign retire = (memwb_q.kind != K_NOP);

  // R12
  retire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    retire |-> ($past(exmem_q.kind) != K_NOP));

endmodule

// File: tb/test_pipe5_core.sv
module test_pipe5_core;

  localparam int IW = 64;
  localparam int DW = 16;
  localparam int IA = 6;
  localparam int DA = 4;
  localparam int NPROG = 17;
  localparam int NCYC = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          imem_load_en = 1'b0;
  logic [IA-1:0] imem_load_idx = '0;
  logic [31:0]   imem_load_word = '0;
  logic          dmem_load_en = 1'b0;
  logic [DA-1:0] dmem_load_idx = '0;
  logic [31:0]   dmem_load_word = '0;
  logic [4:0]    peek_reg_idx = '0;
  logic [31:0]   peek_reg_val;
  logic [DA-1:0] peek_mem_idx = '0;
  logic [31:0]   peek_mem_val;
  logic [31:0]   fetch_pc;
  logic          retire;

  always #5 clk = ~clk;

  pipe5_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_pipe5_core (
    .clk(clk), .rst(rst),
    .imem_load_en(imem_load_en), .imem_load_idx(imem_load_idx), .imem_load_word(imem_load_word),
    .dmem_load_en(dmem_load_en), .dmem_load_idx(dmem_load_idx), .dmem_load_word(dmem_load_word),
    .peek_reg_idx(peek_reg_idx), .peek_reg_val(peek_reg_val),
    .peek_mem_idx(peek_mem_idx), .peek_mem_val(peek_mem_val),
    .fetch_pc(fetch_pc), .retire(retire)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------- encoders ----------
  function automatic logic [31:0] i_form(input logic [5:0] op, input int rs, input int rt, input int imm);
    logic [15:0] im = imm[15:0];
    return {op, rs[4:0], rt[4:0], im};
  endfunction

  function automatic logic [31:0] add_form(input int rd, input int rs, input int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h20};
  endfunction

  // ---------- behavioural reference ----------
  logic [31:0] prog  [NPROG];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DW];
  int          avail [32];
  bit          exp_ret [64];
  bit          stall_at [64];

  function automatic logic [31:0] init_word(input int i);
    if (i == 0) return 32'd5;
    if (i == 1) return 32'hFFFF_FFF0;
    if (i == 2) return 32'd100;
    return i * 32'h11;
  endfunction

  task automatic run_model();
    int prev = 0;
    for (int i = 0; i < 32; i++) begin m_reg[i] = '0; avail[i] = 0; end
    for (int i = 0; i < 64; i++) begin exp_ret[i] = 0; stall_at[i] = 0; end
    for (int i = 0; i < DW; i++) m_mem[i] = init_word(i);
    for (int i = 0; i < NPROG; i++) begin
      logic [31:0] w = prog[i];
      int rs = int'(w[25:21]);
      int rt = int'(w[20:16]);
      int rd = int'(w[15:11]);
      logic [31:0] imm = {{16{w[15]}}, w[15:0]};
      bit is_ld = (w[31:26] == 6'h23);
      bit is_st = (w[31:26] == 6'h2B);
      bit is_sl = (w[31:26] == 6'h0A);
      bit is_ad = (w[31:26] == 6'h00 && w[5:0] == 6'h20 && w[10:6] == 5'd0);
      int d = prev + 1;
      int dst = 0;
      logic [31:0] val = '0;
      logic [31:0] addr;
      if ((is_ld || is_st || is_sl || is_ad) && rs != 0 && avail[rs] > d) d = avail[rs];
      if ((is_st || is_ad) && rt != 0 && avail[rt] > d) d = avail[rt];
      for (int k = prev + 1; k < d; k++) stall_at[k] = 1;
      addr = m_reg[rs] + imm;
      if (is_ld) begin dst = rt; val = m_mem[addr[DA+1:2]]; end
      if (is_st) m_mem[addr[DA+1:2]] = m_reg[rt];
      if (is_sl) begin dst = rt; val = ($signed(m_reg[rs]) < $signed(imm)) ? 32'd1 : 32'd0; end
      if (is_ad) begin dst = rd; val = m_reg[rs] + m_reg[rt]; end
      if (is_ld || is_st || is_sl || is_ad) exp_ret[d + 3] = 1;
      if (dst != 0) begin m_reg[dst] = val; avail[dst] = d + 3; end
      prev = d;
    end
  endtask

  // ---------- stimulus ----------
  initial begin
    int run_steps = 0;
    prog[0]  = i_form(6'h23, 0, 1, 0);        // lw   r1, 0(r0)
    prog[1]  = i_form(6'h23, 0, 2, 4);        // lw   r2, 4(r0)
    prog[2]  = add_form(3, 1, 2);             // add  r3, r1, r2   (distance 1)
    prog[3]  = i_form(6'h0A, 3, 4, -10);      // slti r4, r3, -10  (distance 1)
    prog[4]  = i_form(6'h2B, 0, 3, 12);       // sw   r3, 12(r0)   (distance 2, data source)
    prog[5]  = add_form(5, 4, 4);             // add  r5, r4, r4
    prog[6]  = 32'h0000_0000;                 // no-op
    prog[7]  = i_form(6'h23, 5, 6, 6);        // lw   r6, 6(r5)    (distance 2 over no-op)
    prog[8]  = i_form(6'h0A, 6, 7, 200);      // slti r7, r6, 200
    prog[9]  = add_form(0, 6, 6);             // add  r0, r6, r6   (discarded)
    prog[10] = add_form(8, 0, 6);             // add  r8, r0, r6
    prog[11] = {6'h3F, 5'd8, 5'd13, 16'h0000}; // unknown, rs names pending r8
    prog[12] = i_form(6'h2B, 5, 8, 2);        // sw   r8, 2(r5)
    prog[13] = i_form(6'h23, 0, 9, 4);        // lw   r9, 4(r0)    (after store)
    prog[14] = i_form(6'h2B, 0, 9, 20);       // sw   r9, 20(r0)   (distance 1 on data)
    prog[15] = i_form(6'h0A, 1, 10, 5);       // slti r10, r1, 5
    prog[16] = i_form(6'h0A, 2, 11, 0);       // slti r11, r2, 0
    run_model();

    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      imem_load_en   = 1'b1;
      imem_load_idx  = i[IA-1:0];
      imem_load_word = (i < NPROG) ? prog[i] : 32'h0;
    end
    for (int i = 0; i < DW; i++) begin
      @(negedge clk);
      imem_load_en   = 1'b0;
      dmem_load_en   = 1'b1;
      dmem_load_idx  = i[DA-1:0];
      dmem_load_word = init_word(i);
    end
    @(negedge clk);
    imem_load_en = 1'b0;
    dmem_load_en = 1'b0;
    @(negedge clk);

    // R1 reset state
    peek_reg_idx = 5'd3;
    peek_mem_idx = 4'd1;
    #1;
    check("R1", "fetch_pc in reset", fetch_pc, 32'h0);
    check("R1", "retire in reset", {31'b0, retire}, 32'h0);
    check("R1", "r3 in reset", peek_reg_val, 32'h0);
    check("R13", "preloaded word 1", peek_mem_val, 32'hFFFF_FFF0);

    @(negedge clk);
    rst = 1'b0;
    begin
      int adv = 0;
      for (int k = 1; k <= NCYC; k++) begin
        @(posedge clk);
        if (!stall_at[k-1]) adv++;
        @(negedge clk);
        // R12 retire timing, R7/R11 interlock timing
        check("R12", $sformatf("retire at cycle %0d", k), {31'b0, retire}, {31'b0, exp_ret[k]});
        // R2 fetch step, R8 hold during stall
        check("R8", $sformatf("fetch_pc at cycle %0d", k), fetch_pc, 32'(adv * 4));
        run_steps++;
      end
    end

    // R7: 40 cycles minus 11 stall cycles of advancement
    check("R7", "fetch_pc after run", fetch_pc, 32'd116);

    for (int r = 0; r < 16; r++) begin
      peek_reg_idx = r[4:0];
      #1;
      check("R13", $sformatf("register %0d vs model", r), peek_reg_val, m_reg[r]);
    end
    for (int i = 0; i < DW; i++) begin
      peek_mem_idx = i[DA-1:0];
      #1;
      check("R13", $sformatf("data word %0d vs model", i), peek_mem_val, m_mem[i]);
    end

    peek_reg_idx = 5'd1;  #1; check("R3", "r1 loaded", peek_reg_val, 32'd5);
    peek_reg_idx = 5'd6;  #1; check("R3", "r6 loaded via offset 6(r5)", peek_reg_val, 32'd100);
    peek_reg_idx = 5'd3;  #1; check("R5", "r3 = 5 + -16", peek_reg_val, 32'hFFFF_FFF5);
    peek_reg_idx = 5'd4;  #1; check("R9", "r4 sees r3 written same cycle", peek_reg_val, 32'd1);
    peek_reg_idx = 5'd10; #1; check("R6", "5 < 5 is 0", peek_reg_val, 32'd0);
    peek_reg_idx = 5'd11; #1; check("R6", "-16 < 0 signed", peek_reg_val, 32'd1);
    peek_reg_idx = 5'd0;  #1; check("R10", "r0 after write", peek_reg_val, 32'd0);
    peek_reg_idx = 5'd8;  #1; check("R10", "r8 from r0 + r6", peek_reg_val, 32'd100);
    peek_reg_idx = 5'd13; #1; check("R11", "unknown op left r13", peek_reg_val, 32'd0);
    peek_reg_idx = 5'd9;  #1; check("R4", "load after store", peek_reg_val, 32'd100);
    peek_mem_idx = 4'd3;  #1; check("R4", "stored r3", peek_mem_val, 32'hFFFF_FFF5);
    peek_mem_idx = 4'd5;  #1; check("R4", "stored r9", peek_mem_val, 32'd100);
    peek_mem_idx = 4'd0;  #1; check("R11", "word 0 untouched", peek_mem_val, 32'd5);

    if (run_steps != NCYC) check("R12", "run length", 32'(run_steps), 32'(NCYC));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule